// File: doc/BRIEF.md
# Tiled view address generator

This block turns a pixel position inside a two-dimensional tiled container into the address a master uses to reach that pixel through a rotated or mirrored view. Each request carries a pixel format (8-bit, 16-bit, 32-bit or page mode), a 3-bit view orientation and the X and Y coordinates. The block returns a 32-bit tiled-space address and the line stride for that format and orientation. It also raises a flag when a coordinate does not fit the container.

Rotation and mirroring need no multipliers. Each inversion is an XOR of the coordinate with its full-range mask, and a 90° or 270° view swaps which coordinate supplies the high bits of the offset. Wider pixels leave fewer usable coordinate bits, so the offset is shifted left by the sum of the per-format shifts. With the default parameters the offset always fills bits [26:0]. The block has two register stages with a valid/ready handshake at each end, and it accepts one request per cycle when the downstream side keeps ready high.

Top module: `tiled_view_addr`

## Requirements
- R1: Address bits [28:27] carry the format code: 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for page mode.
- R2: Address bits [31:29] repeat the orientation input. Orientation bit 0 inverts Y, bit 1 inverts X and bit 2 swaps the X and Y roles.
- R3: The (X, Y) shifts are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (6,6) for page mode. With a 14-bit width budget and a 13-bit height budget, the usable bits are therefore X/Y = 14/13, 14/12, 13/12 and 8/7.
- R4: If X or Y is above its usable-bit mask, out_invalid is 1 and out_addr is 0. out_stride is still reported.
- R5: When the X-invert bit is set, X is replaced by X XOR its mask. When the Y-invert bit is set, Y is replaced by Y XOR its mask.
- R6: Without the swap, the offset is (Y << usable X bits) + X. With the swap, it is (X << usable Y bits) + Y. The offset is then shifted left by the X shift plus the Y shift and placed in address bits [26:0].
- R7: out_stride is 1 << (13 + X shift) when the swap bit is set, and 1 << (14 + Y shift) otherwise.
- R8: A request accepted on one clock edge appears on out_valid after the next edge. The block accepts one request every cycle while out_ready stays high.
- R9: While out_valid is high and out_ready is low, the output and all its fields hold unchanged.
- R10: While rst_n is low at a clock edge, out_valid clears. After reset in_ready is 1, and whenever out_valid is low in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request taken on this edge when in_valid is high |
| in_fmt | input | 2 | Pixel format code |
| in_orient | input | 3 | View orientation (bit 0 Y-invert, bit 1 X-invert, bit 2 swap) |
| in_x | input | 16 | X coordinate in pixels |
| in_y | input | 16 | Y coordinate in pixels |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_addr | output | 32 | Tiled-space address |
| out_stride | output | 32 | Line stride in bytes |
| out_invalid | output | 1 | Coordinate out of range |

## Verification
The address, stride and invalid flag all become visible after the second clock edge that follows acceptance. Each vector is driven on a falling edge, and the bench samples at the falling edge after one rising edge, where out_valid must still be low. It samples again at the falling edge after the second rising edge, where all three results must be present. The back-to-back test samples results on consecutive falling edges. The stall test holds out_ready low for several cycles and compares the output on each of those falling edges.

// File: rtl/tva_pkg.sv
// Shared definitions for the tiled view address generator.
// Assumes the format codes double as the address field encoding.
package tva_pkg;

    typedef enum logic [1:0] {
        FMT_B8   = 2'd0,
        FMT_B16  = 2'd1,
        FMT_B32  = 2'd2,
        FMT_PAGE = 2'd3
    } tile_fmt_e;

    localparam int ORI_YINV = 0;
    localparam int ORI_XINV = 1;
    localparam int ORI_SWAP = 2;

    // Horizontal shift for a format; page mode uses the slot width bits.
    function automatic logic [4:0] hshift(input logic [1:0] f, input logic [4:0] slot_bits);
        case (f)
            FMT_B32:  hshift = 5'd1;
            FMT_PAGE: hshift = slot_bits;
            default:  hshift = 5'd0;
        endcase
    endfunction

    // Vertical shift for a format; page mode uses the slot height bits.
    function automatic logic [4:0] vshift(input logic [1:0] f, input logic [4:0] slot_bits);
        case (f)
            FMT_B16,
            FMT_B32:  vshift = 5'd1;
            FMT_PAGE: vshift = slot_bits;
            default:  vshift = 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/tva_front.sv
// First stage: range check and mirroring of the coordinates.
// Assumes COORD_W exceeds both container bit budgets.
module tva_front
    import tva_pkg::*;
#(
    parameter int WB      = 14,
    parameter int HB      = 13,
    parameter int SLOT_WB = 6,
    parameter int SLOT_HB = 6,
    parameter int COORD_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_fmt,
    input  logic [2:0]    in_orient,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic          down_ready,
    output logic          s1_valid,
    output logic [1:0]    s1_fmt,
    output logic [2:0]    s1_orient,
    output logic [WB-1:0] s1_x,
    output logic [HB-1:0] s1_y,
    output logic          s1_inv
);

    localparam logic [5:0] WB6 = 6'(WB);
    localparam logic [5:0] HB6 = 6'(HB);

    logic [4:0]         xs, ys;
    logic [5:0]         xbits, ybits;
    logic [COORD_W-1:0] xmask, ymask, xm, ym;
    logic               bad;

    // Decode the format shifts, masks and mirrored coordinates.
    always_comb begin
        xs    = hshift(in_fmt, 5'(SLOT_WB));
        ys    = vshift(in_fmt, 5'(SLOT_HB));
        xbits = WB6 - {1'b0, xs};
        ybits = HB6 - {1'b0, ys};
        xmask = (COORD_W'(1) << xbits) - COORD_W'(1);
        ymask = (COORD_W'(1) << ybits) - COORD_W'(1);
        bad   = (in_x > xmask) || (in_y > ymask);
        xm    = in_orient[ORI_XINV] ? (in_x ^ xmask) : in_x;
        ym    = in_orient[ORI_YINV] ? (in_y ^ ymask) : in_y;
    end

    assign in_ready = !s1_valid || down_ready;

    // Stage register with handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_fmt    <= '0;
            s1_orient <= '0;
            s1_x      <= '0;
            s1_y      <= '0;
            s1_inv    <= 1'b0;
        end else if (in_ready) begin
            s1_valid <= in_valid;
            if (in_valid) begin
                s1_fmt    <= in_fmt;
                s1_orient <= in_orient;
                s1_x      <= xm[WB-1:0];
                s1_y      <= ym[HB-1:0];
                s1_inv    <= bad;
            end
        end
    end

endmodule

// File: rtl/tva_back.sv
// Second stage: offset composition, alignment shift, field packing and stride.
// Assumes the incoming coordinates already fit their usable bit counts.
module tva_back
    import tva_pkg::*;
#(
    parameter int WB       = 14,
    parameter int HB       = 13,
    parameter int SLOT_WB  = 6,
    parameter int SLOT_HB  = 6,
    parameter int STRIDE_W = 32,
    localparam int OFF_W   = WB + HB,
    localparam int ADDR_W  = OFF_W + 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                s1_valid,
    output logic                s2_ready,
    input  logic [1:0]          s1_fmt,
    input  logic [2:0]          s1_orient,
    input  logic [WB-1:0]       s1_x,
    input  logic [HB-1:0]       s1_y,
    input  logic                s1_inv,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [STRIDE_W-1:0] out_stride,
    output logic                out_invalid
);

    localparam logic [5:0] WB6 = 6'(WB);
    localparam logic [5:0] HB6 = 6'(HB);

    logic [4:0]          xs, ys;
    logic [5:0]          xbits, ybits, align;
    logic [OFF_W-1:0]    raw, off;
    logic [ADDR_W-1:0]   addr_c;
    logic [STRIDE_W-1:0] stride_c;

    // Compose the offset, align it and pack the address fields.
    always_comb begin
        xs    = hshift(s1_fmt, 5'(SLOT_WB));
        ys    = vshift(s1_fmt, 5'(SLOT_HB));
        xbits = WB6 - {1'b0, xs};
        ybits = HB6 - {1'b0, ys};
        align = {1'b0, xs} + {1'b0, ys};
        if (s1_orient[ORI_SWAP])
            raw = (OFF_W'(s1_x) << ybits) + OFF_W'(s1_y);
        else
            raw = (OFF_W'(s1_y) << xbits) + OFF_W'(s1_x);
        off    = raw << align;
        addr_c = s1_inv ? '0 : {s1_orient, s1_fmt, off};
        if (s1_orient[ORI_SWAP])
            stride_c = STRIDE_W'(1) << (HB6 + {1'b0, xs});
        else
            stride_c = STRIDE_W'(1) << (WB6 + {1'b0, ys});
    end

    assign s2_ready = !out_valid || out_ready;

    // Output register, held while downstream stalls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_addr    <= '0;
            out_stride  <= '0;
            out_invalid <= 1'b0;
        end else if (s2_ready) begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_addr    <= addr_c;
                out_stride  <= stride_c;
                out_invalid <= s1_inv;
            end
        end
    end

endmodule

// File: rtl/tiled_view_addr.sv
// Top: two-stage tiled view address generator with valid/ready at both ends.
// Assumes default budgets give a 32-bit address (27 offset bits plus 5 field bits).
module tiled_view_addr #(
    parameter int WB       = 14,
    parameter int HB       = 13,
    parameter int SLOT_WB  = 6,
    parameter int SLOT_HB  = 6,
    parameter int COORD_W  = 16,
    parameter int STRIDE_W = 32,
    localparam int ADDR_W  = WB + HB + 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [1:0]          in_fmt,
    input  logic [2:0]          in_orient,
    input  logic [COORD_W-1:0]  in_x,
    input  logic [COORD_W-1:0]  in_y,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [STRIDE_W-1:0] out_stride,
    output logic                out_invalid
);

    logic          s1_valid, s2_ready, s1_inv;
    logic [1:0]    s1_fmt;
    logic [2:0]    s1_orient;
    logic [WB-1:0] s1_x;
    logic [HB-1:0] s1_y;

    tva_front #(
        .WB(WB), .HB(HB), .SLOT_WB(SLOT_WB), .SLOT_HB(SLOT_HB), .COORD_W(COORD_W)
    ) u_front (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_fmt(in_fmt), .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
        .down_ready(s2_ready),
        .s1_valid(s1_valid), .s1_fmt(s1_fmt), .s1_orient(s1_orient),
        .s1_x(s1_x), .s1_y(s1_y), .s1_inv(s1_inv)
    );

    tva_back #(
        .WB(WB), .HB(HB), .SLOT_WB(SLOT_WB), .SLOT_HB(SLOT_HB), .STRIDE_W(STRIDE_W)
    ) u_back (
        .clk(clk), .rst_n(rst_n),
        .s1_valid(s1_valid), .s2_ready(s2_ready),
        .s1_fmt(s1_fmt), .s1_orient(s1_orient),
        .s1_x(s1_x), .s1_y(s1_y), .s1_inv(s1_inv),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_stride(out_stride), .out_invalid(out_invalid)
    );

endmodule

// File: rtl/tva_chk.sv
// Protocol and encoding checks for tiled_view_addr, attached by bind.
// Assumes the default 32-bit address layout.
module tva_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_addr,
    input logic [31:0] out_stride,
    input logic        out_invalid
);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_addr)
                                    && $stable(out_stride) && $stable(out_invalid));

    // R7
    stride_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_stride) == 1);

    // R6
    page_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_invalid && out_addr[28:27] == 2'd3 |-> out_addr[11:0] == 12'd0);

    // R6
    wide_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_invalid && out_addr[28:27] == 2'd2 |-> out_addr[1:0] == 2'd0);

    // R10
    idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

endmodule

bind tiled_view_addr tva_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_stride(out_stride), .out_invalid(out_invalid)
);

// File: tb/tiled_view_addr_tb.sv
module tiled_view_addr_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, out_valid, out_ready, out_invalid;
    logic [1:0]  in_fmt;
    logic [2:0]  in_orient;
    logic [15:0] in_x, in_y;
    logic [31:0] out_addr, out_stride;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    tiled_view_addr u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_fmt(in_fmt), .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_stride(out_stride), .out_invalid(out_invalid)
    );

    // Stimulus table: {fmt, orient, x, y}
    localparam logic [36:0] VEC [0:13] = '{
        {2'd0, 3'd0, 16'd5,     16'd3},
        {2'd0, 3'd1, 16'd16383, 16'd8191},
        {2'd0, 3'd0, 16'd16384, 16'd0},
        {2'd0, 3'd2, 16'd100,   16'd8192},
        {2'd1, 3'd3, 16'd777,   16'd4095},
        {2'd1, 3'd0, 16'd1,     16'd4096},
        {2'd1, 3'd4, 16'd300,   16'd20},
        {2'd2, 3'd5, 16'd8191,  16'd1},
        {2'd2, 3'd0, 16'd8192,  16'd7},
        {2'd2, 3'd6, 16'd12,    16'd34},
        {2'd3, 3'd7, 16'd255,   16'd127},
        {2'd3, 3'd0, 16'd256,   16'd0},
        {2'd3, 3'd6, 16'd1,     16'd2},
        {2'd3, 3'd2, 16'd17,    16'd128}
    };

    // Requirement-level model of the expected results.
    function automatic void model(input logic [1:0] f, input logic [2:0] o,
                                  input logic [15:0] x, input logic [15:0] y,
                                  output logic [31:0] a, output logic [31:0] s,
                                  output logic inv);
        int xs, ys, xb, yb;
        longint xm, ym, xe, ye, off;
        case (f)
            2'd0: begin xs = 0; ys = 0; end
            2'd1: begin xs = 0; ys = 1; end
            2'd2: begin xs = 1; ys = 1; end
            default: begin xs = 6; ys = 6; end
        endcase
        xb = 14 - xs;
        yb = 13 - ys;
        xm = (64'd1 << xb) - 1;
        ym = (64'd1 << yb) - 1;
        inv = (longint'(x) > xm) || (longint'(y) > ym);
        xe = o[1] ? (longint'(x) ^ xm) : longint'(x);
        ye = o[0] ? (longint'(y) ^ ym) : longint'(y);
        off = o[2] ? ((xe << yb) + ye) : ((ye << xb) + xe);
        off = off << (xs + ys);
        a = inv ? 32'd0 : {o, f, off[26:0]};
        s = o[2] ? (32'd1 << (13 + xs)) : (32'd1 << (14 + ys));
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Compare the current output against the model.
    task automatic chk_out(input logic [1:0] f, input logic [2:0] o,
                           input logic [15:0] x, input logic [15:0] y, input string tag);
        logic [31:0] ea, es;
        logic ei;
        model(f, o, x, y, ea, es, ei);
        chk(out_valid === 1'b1, {tag, " R8 valid"}, 32'(out_valid), 32'd1);
        chk(out_addr === ea, {tag, " R1 R2 R3 R5 R6 addr"}, out_addr, ea);
        chk(out_stride === es, {tag, " R7 stride"}, out_stride, es);
        chk(out_invalid === ei, {tag, " R4 invalid"}, 32'(out_invalid), 32'(ei));
    endtask

    // Send one request alone and check latency and result.
    task automatic one_shot(input logic [1:0] f, input logic [2:0] o,
                            input logic [15:0] x, input logic [15:0] y, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_fmt = f; in_orient = o; in_x = x; in_y = y;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b0, {tag, " R8 not early"}, 32'(out_valid), 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk_out(f, o, x, y, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        in_fmt = '0; in_orient = '0; in_x = '0; in_y = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk(out_valid === 1'b0, "R10 out_valid in reset", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1, "R10 in_ready after reset", 32'(in_ready), 32'd1);

        // Table walk
        for (int i = 0; i < 14; i++)
            one_shot(VEC[i][36:35], VEC[i][34:32], VEC[i][31:16], VEC[i][15:0], $sformatf("vec%0d", i));

        // R6 hand-computed: 8-bit, no rotation, x=5 y=3
        one_shot(2'd0, 3'd0, 16'd5, 16'd3, "R6 direct");
        chk(out_addr === 32'h0000C005, "R6 direct addr", out_addr, 32'h0000C005);
        chk(out_stride === 32'd16384, "R7 direct stride", out_stride, 32'd16384);

        // R2 R5 hand-computed: page mode, swap + X-invert, x=1 y=2
        one_shot(2'd3, 3'd6, 16'd1, 16'd2, "R2 direct");
        chk(out_addr === 32'hDFF02000, "R2 R5 direct addr", out_addr, 32'hDFF02000);
        chk(out_stride === 32'd524288, "R7 swapped stride", out_stride, 32'd524288);

        // R4 invalid gives zero address
        one_shot(2'd2, 3'd7, 16'd9000, 16'd5, "R4 direct");
        chk(out_addr === 32'd0 && out_invalid === 1'b1, "R4 zero address", out_addr, 32'd0);

        // R8 back-to-back throughput
        @(negedge clk);
        in_valid = 1'b1; in_fmt = 2'd1; in_orient = 3'd0; in_x = 16'd10; in_y = 16'd11;
        @(negedge clk);
        in_fmt = 2'd2; in_orient = 3'd3; in_x = 16'd20; in_y = 16'd21;
        @(negedge clk);
        in_fmt = 2'd0; in_orient = 3'd5; in_x = 16'd30; in_y = 16'd31;
        chk_out(2'd1, 3'd0, 16'd10, 16'd11, "R8 b2b0");
        @(negedge clk);
        in_valid = 1'b0;
        chk_out(2'd2, 3'd3, 16'd20, 16'd21, "R8 b2b1");
        @(negedge clk);
        chk_out(2'd0, 3'd5, 16'd30, 16'd31, "R8 b2b2");
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 drained", 32'(out_valid), 32'd0);

        // R9 stall: two requests, downstream not ready
        out_ready = 1'b0;
        in_valid = 1'b1; in_fmt = 2'd3; in_orient = 3'd1; in_x = 16'd40; in_y = 16'd50;
        @(negedge clk);
        in_fmt = 2'd1; in_orient = 3'd6; in_x = 16'd60; in_y = 16'd70;
        @(negedge clk);
        @(negedge clk);
        chk(in_ready === 1'b0, "R9 backpressure", 32'(in_ready), 32'd0);
        in_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk_out(2'd3, 3'd1, 16'd40, 16'd50, "R9 hold");
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk_out(2'd1, 3'd6, 16'd60, 16'd70, "R9 release");
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 empty", 32'(out_valid), 32'd0);

        // R10 reset mid-flight clears output
        in_valid = 1'b1; in_fmt = 2'd0; in_orient = 3'd0; in_x = 16'd1; in_y = 16'd1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 reset flush", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R10 nothing after flush", 32'(out_valid), 32'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule